// File: doc/BRIEF.md
# Commit-Stage Squash Request Controller

This block sits at the commit end of an out-of-order core and picks one squash per thread out of three possible sources. The first is a trap squash, which fires a programmable number of cycles after a faulting instruction reaches the head of the reorder buffer. The second is a thread-context squash that flushes the whole thread. The third is a squash from the execute stage, raised by a misprediction or a replay. For the request it accepts, the block broadcasts a squash command to the earlier stages: a done sequence number, the branch outcome flags and the redirect PCs. It does not walk the reorder buffer and it does not redirect fetch. It only issues the commands and their fields.

Each thread keeps a register that holds the youngest sequence number written into its reorder buffer. The block uses this register to drop stale execute-stage squashes. A stale squash is one for a younger instruction than the youngest live entry, which would otherwise override a squash for an older instruction. Each thread runs a four-state machine with the states IDLE, RUN, TRAPWAIT and WALK (encodings 0, 1, 2 and 3 on `thread_state`). The transitions are:

- IDLE to RUN on the first insert.
- RUN to TRAPWAIT on a trap request.
- TRAPWAIT to WALK when the trap timer expires.
- Any state except TRAPWAIT to WALK on an accepted context or execute squash.
- WALK to RUN when the reorder buffer reports that its walk is done.

At the top level, the block counts the threads that are in WALK, holds back commit only when every thread is walking, and keeps a running count of accepted mispredictions.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset every thread is in IDLE (0), no squash or walk flag is raised, the misprediction count is 0, `squash_count` is 0 and `commit_allowed` is 1.
- R2: A thread in IDLE moves to RUN (1) at the clock edge where an insert for it is presented.
- R3: A trap request in RUN moves the thread to TRAPWAIT (2). The squash is broadcast max(`trap_delay`,1) edges after the request edge. It carries a done sequence of ROB head minus 1, or 0 when the ROB is empty, next PC equal to `thread_pc`, and mispredict and taken both 0.
- R4: A context squash is broadcast at the edge where it is presented, with the same fields as in R3. While the thread is in TRAPWAIT, a context squash is ignored.
- R5: An execute squash is accepted only if its sequence is less than or equal to the thread's youngest register and the thread is not in TRAPWAIT. Otherwise it raises no broadcast and leaves the state unchanged.
- R6: When the include flag is set, the accepted squash uses the request sequence minus 1. That value is both the broadcast done sequence and the new youngest value.
- R7: An insert sets the youngest register to its sequence, except at an edge where a squash is accepted for that thread. An accepted execute squash loads the youngest register from R6, and a trap or context squash clears it to 0.
- R8: Within a thread, the priority order is: trap timer expiry, then context squash, then execute squash, then trap request. A request that loses the priority has no effect at that edge.
- R9: An accepted squash puts the thread in WALK (3) and raises `sq_rob_walking`. The thread holds WALK with the flag high until `rob_walk_done` is seen, and then moves to RUN.
- R10: `mispredict_count` rises by the number of accepted execute squashes whose mispredict flag is set, at the edge where they are accepted.
- R11: `squash_count` gives the number of threads in WALK. `commit_allowed` is 0 only when that number equals the thread count.
- R12: An accepted execute squash forwards its mispredict flag, taken flag, next PC and mispredicted PC on the broadcast for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_delay | input | LAT_W | Cycles from trap request to trap squash |
| trap_req | input | NTHR | Faulting head instruction, per thread |
| ctx_squash_req | input | NTHR | Whole-thread context squash request |
| ex_squash_vld | input | NTHR | Execute-stage squash request |
| ex_squash_seq | input | NTHR*SEQ_W | Squashing instruction sequence |
| ex_include_inst | input | NTHR | Squash the squashing instruction too |
| ex_mispredict | input | NTHR | Request is a branch misprediction |
| ex_taken | input | NTHR | Resolved branch direction |
| ex_next_pc | input | NTHR*PC_W | Redirect PC from execute |
| ex_mispred_pc | input | NTHR*PC_W | PC of the mispredicted branch |
| thread_pc | input | NTHR*PC_W | Current commit PC, used for full flushes |
| rob_head_seq | input | NTHR*SEQ_W | Sequence number at the ROB head |
| rob_empty | input | NTHR | ROB holds no entry for the thread |
| rob_walk_done | input | NTHR | ROB finished the squash walk |
| ins_vld | input | NTHR | Instruction inserted into the ROB |
| ins_seq | input | NTHR*SEQ_W | Sequence number of the inserted instruction |
| thread_state | output | NTHR*2 | Per-thread state encoding |
| sq_valid | output | NTHR | One-cycle squash broadcast |
| sq_rob_walking | output | NTHR | Thread is in the ROB walk |
| sq_done_seq | output | NTHR*SEQ_W | Oldest surviving sequence number |
| sq_mispredict | output | NTHR | Broadcast mispredict flag |
| sq_taken | output | NTHR | Broadcast taken flag |
| sq_next_pc | output | NTHR*PC_W | Broadcast redirect PC |
| sq_mispred_pc | output | NTHR*PC_W | Broadcast mispredicted PC |
| squash_count | output | SC_W | Number of walking threads |
| commit_allowed | output | 1 | Low only when every thread walks |
| mispredict_count | output | MC_W | Accepted mispredictions |

## Verification
The checker watches several properties on every cycle:

- WALK is held until the walk-done input arrives.
- A broadcast always coincides with WALK.
- A thread in TRAPWAIT stays silent and can leave only for WALK.
- The misprediction count tracks the broadcasts that carry the mispredict flag.
- Commit is held back only when all threads walk.

The properties that depend on what the block remembers can only be shown by the directed scenarios: which squash the age filter admits, the exact sequence field values, the trap delay count, and the priority within one cycle.

// File: rtl/cmsq_pkg.sv
package cmsq_pkg;

    typedef enum logic [1:0] {
        TS_IDLE     = 2'd0,
        TS_RUN      = 2'd1,
        TS_TRAPWAIT = 2'd2,
        TS_WALK     = 2'd3
    } thr_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TRAP = 2'd1,
        SRC_CTX  = 2'd2,
        SRC_EXEC = 2'd3
    } sq_src_e;

endpackage

// File: rtl/cmsq_trap_timer.sv
module cmsq_trap_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LAT_W-1:0] delay,
    output logic             fire
);
    logic             busy;
    logic [LAT_W-1:0] remain;

    // A delay of zero behaves like a delay of one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (arm) begin
            busy   <= 1'b1;
            remain <= (delay == '0) ? '0 : delay - LAT_W'(1);
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - LAT_W'(1);
            end
        end
    end

    assign fire = busy && (remain == '0);
endmodule

// File: rtl/cmsq_age_filter.sv
module cmsq_age_filter #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_vld,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             flush_clr,
    input  logic             ex_load,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    output logic             in_range,
    output logic [SEQ_W-1:0] eff_seq
);
    logic [SEQ_W-1:0] youngest;

    always_comb begin
        in_range = (ex_seq <= youngest);
        eff_seq  = ex_incl ? ex_seq - SEQ_W'(1) : ex_seq;
    end

    // A squash in the same cycle wins over an insert.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            youngest <= '0;
        end else if (flush_clr) begin
            youngest <= '0;
        end else if (ex_load) begin
            youngest <= eff_seq;
        end else if (ins_vld) begin
            youngest <= ins_seq;
        end
    end
endmodule

// File: rtl/cmsq_thread_ctrl.sv
module cmsq_thread_ctrl
    import cmsq_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] trap_delay,
    input  logic             trap_req,
    input  logic             ctx_req,
    input  logic             ex_vld,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ex_misp,
    input  logic             ex_taken,
    input  logic [PC_W-1:0]  ex_npc,
    input  logic [PC_W-1:0]  ex_mpc,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             rob_empty,
    input  logic             walk_done,
    input  logic             ins_vld,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic [1:0]       state_o,
    output logic             sq_valid,
    output logic             rob_walking,
    output logic [SEQ_W-1:0] done_seq,
    output logic             sq_misp,
    output logic             sq_taken,
    output logic [PC_W-1:0]  sq_npc,
    output logic [PC_W-1:0]  sq_mpc,
    output logic             misp_event
);
    thr_state_e       state_q, state_d;
    sq_src_e          src;
    logic             trap_fire;
    logic             in_range;
    logic [SEQ_W-1:0] eff_seq;
    logic             ex_ok, ctx_ok, trap_ok, full_flush;
    logic [SEQ_W-1:0] flush_seq;

    cmsq_trap_timer #(.LAT_W(LAT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (trap_ok),
        .delay (trap_delay),
        .fire  (trap_fire)
    );

    cmsq_age_filter #(.SEQ_W(SEQ_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_vld   (ins_vld),
        .ins_seq   (ins_seq),
        .flush_clr (full_flush),
        .ex_load   (src == SRC_EXEC),
        .ex_seq    (ex_seq),
        .ex_incl   (ex_incl),
        .in_range  (in_range),
        .eff_seq   (eff_seq)
    );

    // Source selection: timer expiry, context, execute, then trap request.
    always_comb begin
        ctx_ok  = ctx_req && (state_q != TS_TRAPWAIT);
        ex_ok   = ex_vld && in_range && (state_q != TS_TRAPWAIT);
        if (trap_fire && (state_q == TS_TRAPWAIT)) begin
            src = SRC_TRAP;
        end else if (ctx_ok) begin
            src = SRC_CTX;
        end else if (ex_ok) begin
            src = SRC_EXEC;
        end else begin
            src = SRC_NONE;
        end
        trap_ok    = trap_req && (state_q == TS_RUN) && (src == SRC_NONE);
        full_flush = (src == SRC_TRAP) || (src == SRC_CTX);
        flush_seq  = rob_empty ? '0 : head_seq - SEQ_W'(1);
        misp_event = (src == SRC_EXEC) && ex_misp;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (src != SRC_NONE) begin
            state_d = TS_WALK;
        end else begin
            unique case (state_q)
                TS_IDLE:     if (ins_vld)   state_d = TS_RUN;
                TS_RUN:      if (trap_ok)   state_d = TS_TRAPWAIT;
                TS_TRAPWAIT: state_d = TS_TRAPWAIT;
                TS_WALK:     if (walk_done) state_d = TS_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Broadcast registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_valid <= 1'b0;
            done_seq <= '0;
            sq_misp  <= 1'b0;
            sq_taken <= 1'b0;
            sq_npc   <= '0;
            sq_mpc   <= '0;
        end else begin
            sq_valid <= (src != SRC_NONE);
            if (full_flush) begin
                done_seq <= flush_seq;
                sq_misp  <= 1'b0;
                sq_taken <= 1'b0;
                sq_npc   <= cur_pc;
                sq_mpc   <= '0;
            end else if (src == SRC_EXEC) begin
                done_seq <= eff_seq;
                sq_misp  <= ex_misp;
                sq_taken <= ex_taken;
                sq_npc   <= ex_npc;
                sq_mpc   <= ex_mpc;
            end
        end
    end

    assign rob_walking = (state_q == TS_WALK);
    assign state_o     = state_q;
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl #(
    parameter int NTHR  = 2,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int LAT_W = 8,
    parameter int MC_W  = 32,
    localparam int SC_W = $clog2(NTHR + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LAT_W-1:0]      trap_delay,
    input  logic [NTHR-1:0]       trap_req,
    input  logic [NTHR-1:0]       ctx_squash_req,
    input  logic [NTHR-1:0]       ex_squash_vld,
    input  logic [NTHR*SEQ_W-1:0] ex_squash_seq,
    input  logic [NTHR-1:0]       ex_include_inst,
    input  logic [NTHR-1:0]       ex_mispredict,
    input  logic [NTHR-1:0]       ex_taken,
    input  logic [NTHR*PC_W-1:0]  ex_next_pc,
    input  logic [NTHR*PC_W-1:0]  ex_mispred_pc,
    input  logic [NTHR*PC_W-1:0]  thread_pc,
    input  logic [NTHR*SEQ_W-1:0] rob_head_seq,
    input  logic [NTHR-1:0]       rob_empty,
    input  logic [NTHR-1:0]       rob_walk_done,
    input  logic [NTHR-1:0]       ins_vld,
    input  logic [NTHR*SEQ_W-1:0] ins_seq,
    output logic [NTHR*2-1:0]     thread_state,
    output logic [NTHR-1:0]       sq_valid,
    output logic [NTHR-1:0]       sq_rob_walking,
    output logic [NTHR*SEQ_W-1:0] sq_done_seq,
    output logic [NTHR-1:0]       sq_mispredict,
    output logic [NTHR-1:0]       sq_taken,
    output logic [NTHR*PC_W-1:0]  sq_next_pc,
    output logic [NTHR*PC_W-1:0]  sq_mispred_pc,
    output logic [SC_W-1:0]       squash_count,
    output logic                  commit_allowed,
    output logic [MC_W-1:0]       mispredict_count
);
    logic [NTHR-1:0] misp_ev;
    logic [MC_W-1:0] misp_inc;
    logic [MC_W-1:0] misp_cnt_q;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        cmsq_thread_ctrl #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_thr (
            .clk         (clk),
            .rst_n       (rst_n),
            .trap_delay  (trap_delay),
            .trap_req    (trap_req[t]),
            .ctx_req     (ctx_squash_req[t]),
            .ex_vld      (ex_squash_vld[t]),
            .ex_seq      (ex_squash_seq[t*SEQ_W +: SEQ_W]),
            .ex_incl     (ex_include_inst[t]),
            .ex_misp     (ex_mispredict[t]),
            .ex_taken    (ex_taken[t]),
            .ex_npc      (ex_next_pc[t*PC_W +: PC_W]),
            .ex_mpc      (ex_mispred_pc[t*PC_W +: PC_W]),
            .cur_pc      (thread_pc[t*PC_W +: PC_W]),
            .head_seq    (rob_head_seq[t*SEQ_W +: SEQ_W]),
            .rob_empty   (rob_empty[t]),
            .walk_done   (rob_walk_done[t]),
            .ins_vld     (ins_vld[t]),
            .ins_seq     (ins_seq[t*SEQ_W +: SEQ_W]),
            .state_o     (thread_state[t*2 +: 2]),
            .sq_valid    (sq_valid[t]),
            .rob_walking (sq_rob_walking[t]),
            .done_seq    (sq_done_seq[t*SEQ_W +: SEQ_W]),
            .sq_misp     (sq_mispredict[t]),
            .sq_taken    (sq_taken[t]),
            .sq_npc      (sq_next_pc[t*PC_W +: PC_W]),
            .sq_mpc      (sq_mispred_pc[t*PC_W +: PC_W]),
            .misp_event  (misp_ev[t])
        );
    end

    always_comb begin
        squash_count = '0;
        misp_inc     = '0;
        for (int t = 0; t < NTHR; t++) begin
            squash_count = squash_count + SC_W'(sq_rob_walking[t]);
            misp_inc     = misp_inc + MC_W'(misp_ev[t]);
        end
        commit_allowed = (squash_count != SC_W'(NTHR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            misp_cnt_q <= '0;
        end else begin
            misp_cnt_q <= misp_cnt_q + misp_inc;
        end
    end

    assign mispredict_count = misp_cnt_q;
endmodule

// File: rtl/cmsq_checker.sv
module cmsq_checker #(
    parameter int NTHR = 2,
    parameter int MC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NTHR*2-1:0] thread_state,
    input logic [NTHR-1:0]   sq_valid,
    input logic [NTHR-1:0]   sq_rob_walking,
    input logic [NTHR-1:0]   sq_mispredict,
    input logic [NTHR-1:0]   rob_walk_done,
    input logic              commit_allowed,
    input logic [MC_W-1:0]   mispredict_count
);
    for (genvar t = 0; t < NTHR; t++) begin : g_chk
        p_walk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_state[t*2 +: 2] == 2'd3 && !rob_walk_done[t]) |=> (thread_state[t*2 +: 2] == 2'd3));
        p_bcast_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
            sq_valid[t] |-> (thread_state[t*2 +: 2] == 2'd3 && sq_rob_walking[t]));
        p_trap_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_state[t*2 +: 2] == 2'd2) |-> !sq_valid[t]);
        p_trap_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_state[t*2 +: 2] == 2'd2) |=> (thread_state[t*2 +: 2] inside {2'd2, 2'd3}));
        p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_state[t*2 +: 2] == 2'd0) |-> !sq_rob_walking[t]);
    end

    p_misp_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_count == $past(mispredict_count) + MC_W'($countones(sq_valid & sq_mispredict)));

    p_commit_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_allowed |-> (&sq_rob_walking));
endmodule

bind commit_squash_ctrl cmsq_checker #(.NTHR(NTHR), .MC_W(MC_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .thread_state     (thread_state),
    .sq_valid         (sq_valid),
    .sq_rob_walking   (sq_rob_walking),
    .sq_mispredict    (sq_mispredict),
    .rob_walk_done    (rob_walk_done),
    .commit_allowed   (commit_allowed),
    .mispredict_count (mispredict_count)
);

// File: tb/commit_squash_ctrl_tb.sv
module commit_squash_ctrl_tb;
    localparam int NTHR  = 2;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;
    localparam int LAT_W = 8;
    localparam int MC_W  = 32;
    localparam int SC_W  = $clog2(NTHR + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [LAT_W-1:0]      trap_delay = '0;
    logic [NTHR-1:0]       trap_req = '0, ctx_squash_req = '0, ex_squash_vld = '0;
    logic [NTHR*SEQ_W-1:0] ex_squash_seq = '0;
    logic [NTHR-1:0]       ex_include_inst = '0, ex_mispredict = '0, ex_taken = '0;
    logic [NTHR*PC_W-1:0]  ex_next_pc = '0, ex_mispred_pc = '0, thread_pc = '0;
    logic [NTHR*SEQ_W-1:0] rob_head_seq = '0;
    logic [NTHR-1:0]       rob_empty = '1, rob_walk_done = '0, ins_vld = '0;
    logic [NTHR*SEQ_W-1:0] ins_seq = '0;
    logic [NTHR*2-1:0]     thread_state;
    logic [NTHR-1:0]       sq_valid, sq_rob_walking, sq_mispredict, sq_taken;
    logic [NTHR*SEQ_W-1:0] sq_done_seq;
    logic [NTHR*PC_W-1:0]  sq_next_pc, sq_mispred_pc;
    logic [SC_W-1:0]       squash_count;
    logic                  commit_allowed;
    logic [MC_W-1:0]       mispredict_count;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    commit_squash_ctrl #(.NTHR(NTHR), .SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W), .MC_W(MC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_delay(trap_delay), .trap_req(trap_req),
        .ctx_squash_req(ctx_squash_req), .ex_squash_vld(ex_squash_vld),
        .ex_squash_seq(ex_squash_seq), .ex_include_inst(ex_include_inst),
        .ex_mispredict(ex_mispredict), .ex_taken(ex_taken), .ex_next_pc(ex_next_pc),
        .ex_mispred_pc(ex_mispred_pc), .thread_pc(thread_pc), .rob_head_seq(rob_head_seq),
        .rob_empty(rob_empty), .rob_walk_done(rob_walk_done), .ins_vld(ins_vld),
        .ins_seq(ins_seq), .thread_state(thread_state), .sq_valid(sq_valid),
        .sq_rob_walking(sq_rob_walking), .sq_done_seq(sq_done_seq),
        .sq_mispredict(sq_mispredict), .sq_taken(sq_taken), .sq_next_pc(sq_next_pc),
        .sq_mispred_pc(sq_mispred_pc), .squash_count(squash_count),
        .commit_allowed(commit_allowed), .mispredict_count(mispredict_count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock edge, then drop every one-cycle request.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        trap_req = '0; ctx_squash_req = '0; ex_squash_vld = '0; ex_include_inst = '0;
        ex_mispredict = '0; ex_taken = '0; rob_walk_done = '0; ins_vld = '0;
    endtask

    function automatic logic [1:0] st(input int t);
        return thread_state[t*2 +: 2];
    endfunction

    function automatic logic [SEQ_W-1:0] dseq(input int t);
        return sq_done_seq[t*SEQ_W +: SEQ_W];
    endfunction

    task automatic insert(input int t, input int seq);
        ins_vld[t] = 1'b1;
        ins_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(seq);
    endtask

    task automatic ex_req(input int t, input int seq, input logic incl, input logic misp);
        ex_squash_vld[t] = 1'b1;
        ex_squash_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(seq);
        ex_include_inst[t] = incl;
        ex_mispredict[t] = misp;
    endtask

    task automatic walk_end(input int t);
        rob_walk_done[t] = 1'b1;
        step();
    endtask

    task automatic t_reset();
        check("R1 state0", 64'(st(0)), 64'd0);
        check("R1 state1", 64'(st(1)), 64'd0);
        check("R1 valid", 64'(sq_valid), 64'd0);
        check("R1 walking", 64'(sq_rob_walking), 64'd0);
        check("R1 misp count", 64'(mispredict_count), 64'd0);
        check("R1 squash count", 64'(squash_count), 64'd0);
        check("R1 commit allowed", 64'(commit_allowed), 64'd1);
    endtask

    task automatic t_insert();
        insert(0, 10);
        step();
        check("R2 thread0 run", 64'(st(0)), 64'd1);
        check("R2 thread1 idle", 64'(st(1)), 64'd0);
    endtask

    task automatic t_exec_accept();
        ex_req(0, 7, 1'b0, 1'b1);
        ex_taken[0] = 1'b1;
        ex_next_pc[0 +: PC_W] = 32'h2000;
        ex_mispred_pc[0 +: PC_W] = 32'h1ffc;
        step();
        check("R5 accepted valid", 64'(sq_valid[0]), 64'd1);
        check("R5 done seq", 64'(dseq(0)), 64'd7);
        check("R12 mispredict", 64'(sq_mispredict[0]), 64'd1);
        check("R12 taken", 64'(sq_taken[0]), 64'd1);
        check("R12 next pc", 64'(sq_next_pc[0 +: PC_W]), 64'h2000);
        check("R12 mispred pc", 64'(sq_mispred_pc[0 +: PC_W]), 64'h1ffc);
        check("R9 walk state", 64'(st(0)), 64'd3);
        check("R10 count", 64'(mispredict_count), 64'd1);
        check("R11 squash count", 64'(squash_count), 64'd1);
        check("R11 commit allowed", 64'(commit_allowed), 64'd1);
        step();
        check("R9 pulse one cycle", 64'(sq_valid[0]), 64'd0);
        check("R9 still walking", 64'(sq_rob_walking[0]), 64'd1);
        walk_end(0);
        check("R9 back to run", 64'(st(0)), 64'd1);
        check("R9 walk flag low", 64'(sq_rob_walking[0]), 64'd0);
    endtask

    task automatic t_exec_reject_include();
        ex_req(0, 8, 1'b0, 1'b1);
        step();
        check("R5 younger rejected", 64'(sq_valid[0]), 64'd0);
        check("R5 state kept", 64'(st(0)), 64'd1);
        check("R10 no count on reject", 64'(mispredict_count), 64'd1);
        ex_req(0, 7, 1'b1, 1'b0);
        step();
        check("R6 include valid", 64'(sq_valid[0]), 64'd1);
        check("R6 include done seq", 64'(dseq(0)), 64'd6);
        check("R10 no count without flag", 64'(mispredict_count), 64'd1);
        walk_end(0);
        ex_req(0, 7, 1'b0, 1'b0);
        step();
        check("R6 youngest is seq-1", 64'(sq_valid[0]), 64'd0);
    endtask

    task automatic t_youngest();
        insert(0, 40);
        ex_req(0, 5, 1'b0, 1'b0);
        step();
        check("R7 squash with insert", 64'(dseq(0)), 64'd5);
        walk_end(0);
        ex_req(0, 6, 1'b0, 1'b0);
        step();
        check("R7 insert blocked by squash", 64'(sq_valid[0]), 64'd0);
        insert(0, 50);
        step();
        ex_req(0, 45, 1'b0, 1'b0);
        step();
        check("R7 insert updates youngest", 64'(sq_valid[0]), 64'd1);
        walk_end(0);
    endtask

    task automatic t_trap();
        rob_empty[0] = 1'b0;
        rob_head_seq[0 +: SEQ_W] = 16'd15;
        thread_pc[0 +: PC_W] = 32'h100;
        trap_delay = 8'd3;
        trap_req[0] = 1'b1;
        step();
        check("R3 trapwait", 64'(st(0)), 64'd2);
        ex_req(0, 1, 1'b0, 1'b1);
        step();
        check("R5 ignored in trapwait", 64'(sq_valid[0]), 64'd0);
        check("R5 trapwait kept", 64'(st(0)), 64'd2);
        ctx_squash_req[0] = 1'b1;
        step();
        check("R4 context ignored in trapwait", 64'(sq_valid[0]), 64'd0);
        step();
        check("R3 fires after delay", 64'(sq_valid[0]), 64'd1);
        check("R3 done seq head-1", 64'(dseq(0)), 64'd14);
        check("R3 next pc", 64'(sq_next_pc[0 +: PC_W]), 64'h100);
        check("R3 no mispredict", 64'(sq_mispredict[0]), 64'd0);
        check("R3 walk", 64'(st(0)), 64'd3);
        check("R10 trap not counted", 64'(mispredict_count), 64'd1);
        walk_end(0);
        ex_req(0, 3, 1'b0, 1'b0);
        step();
        check("R7 cleared by full flush", 64'(sq_valid[0]), 64'd0);
    endtask

    task automatic t_context();
        rob_empty[0] = 1'b1;
        ctx_squash_req[0] = 1'b1;
        step();
        check("R4 context valid", 64'(sq_valid[0]), 64'd1);
        check("R4 empty done seq", 64'(dseq(0)), 64'd0);
        check("R4 next pc", 64'(sq_next_pc[0 +: PC_W]), 64'h100);
        walk_end(0);
        trap_delay = 8'd0;
        trap_req[0] = 1'b1;
        step();
        check("R3 zero delay trapwait", 64'(st(0)), 64'd2);
        step();
        check("R3 zero delay fires", 64'(sq_valid[0]), 64'd1);
        walk_end(0);
    endtask

    task automatic t_priority();
        insert(0, 30);
        step();
        ctx_squash_req[0] = 1'b1;
        ex_req(0, 25, 1'b0, 1'b1);
        step();
        check("R8 context beats execute", 64'(dseq(0)), 64'd0);
        check("R8 no mispredict", 64'(sq_mispredict[0]), 64'd0);
        check("R8 count unchanged", 64'(mispredict_count), 64'd1);
        walk_end(0);
        insert(0, 30);
        step();
        trap_delay = 8'd1;
        ex_req(0, 20, 1'b0, 1'b0);
        trap_req[0] = 1'b1;
        step();
        check("R8 execute beats trap", 64'(st(0)), 64'd3);
        check("R8 execute seq", 64'(dseq(0)), 64'd20);
        walk_end(0);
        step();
        step();
        check("R8 lost trap never fires", 64'(sq_valid[0]), 64'd0);
        check("R8 state run", 64'(st(0)), 64'd1);
    endtask

    task automatic t_all_walk();
        insert(1, 5);
        step();
        ex_req(0, 10, 1'b0, 1'b1);
        ex_req(1, 5, 1'b0, 1'b1);
        step();
        check("R11 all walking", 64'(sq_rob_walking), 64'd3);
        check("R11 squash count two", 64'(squash_count), 64'd2);
        check("R11 commit held", 64'(commit_allowed), 64'd0);
        check("R10 two at once", 64'(mispredict_count), 64'd3);
        walk_end(0);
        check("R11 commit resumes", 64'(commit_allowed), 64'd1);
        check("R11 squash count one", 64'(squash_count), 64'd1);
        check("R9 thread1 still walks", 64'(st(1)), 64'd3);
        walk_end(1);
        check("R9 thread1 run", 64'(st(1)), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_insert();
        t_exec_accept();
        t_exec_reject_include();
        t_youngest();
        t_trap();
        t_context();
        t_priority();
        t_all_walk();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule